// File: doc/BRIEF.md
# Configurable 8/9-Bit Serial Receiver

This block recovers characters from an asynchronous serial line. An external generator supplies a strobe at sixteen times the bit rate. Each frame begins with a low start bit, carries 8 or 9 data bits least significant bit first, may carry one even-parity bit, and ends with a high stop bit. Every bit is resolved by a vote of three samples taken around its centre. The received character is held in a one-deep holding register, together with a ninth-bit flag and per-character error flags.

In 9-bit mode an address filter can drop any frame whose ninth bit is low, so a node only sees address frames until it turns the filter off. A wake-up strobe reports every falling edge of the line while wake is enabled. A module-enable input resets the receive path: it discards the held character, clears the flags and the receiver enable, and abandons any frame in progress. The configuration inputs are not touched by this and apply again as soon as the module is re-enabled.

The sequencer has five states. IDLE waits for a low sample on a tick. START checks the start bit and goes to DATA if it is confirmed, or back to IDLE if it is a false start. DATA shifts bits and, after the last data bit, goes to PARITY when parity is enabled or to STOP when it is not. PARITY goes to STOP. STOP resolves the stop bit, delivers the frame and returns to IDLE. Any state goes to IDLE while the receiver is inactive.

Top module: `uart9_rx`

## Requirements
- R1: In 8-bit mode (`len9`=0) a frame's eight data bits, first bit received into bit 0, appear on `rdata`, `rxif` goes to 1 and `rbit8` reads 0.
- R2: In 9-bit mode (`len9`=1) the ninth received bit is presented on `rbit8` and the first eight on `rdata`.
- R3: With `par_en`=1 one parity bit follows the data and `perr` is 1 when the ones count over data plus parity bit is odd. With `par_en`=0 no parity slot exists and `perr` is 0.
- R4: Each bit is the majority of samples 7, 8 and 9 of its sixteen ticks. `nf` is 1 if those three samples disagreed in any bit of the stored frame.
- R5: `ferr` is 1 when the resolved stop bit is 0. The character is still stored.
- R6: A frame that completes while `rxif` is 1 sets `oerr` and is dropped, so `rdata` is unchanged. A pulse on `rd_strobe` clears both `rxif` and `oerr`.
- R7: With `len9`=1 and `addr_det`=1, a frame whose ninth bit is 0 leaves `rxif` and `rdata` untouched. A frame whose ninth bit is 1 is stored.
- R8: `irq` is 1 exactly when `rxif` is 1 and `rie` is 1.
- R9: `ridle` is 0 from a detected start bit until the stop bit is resolved, and 1 otherwise.
- R10: While `mod_en`=0 the flags `rxif`, `oerr`, `ferr`, `perr`, `nf` are 0, `rdata` and `rbit8` are 0, `ren_q` is 0, `ridle` is 1, and a frame in progress is abandoned.
- R11: After `mod_en` returns to 1 the configuration inputs act as before, while `ren_q` stays 0 until it is written again.
- R12: With `wake_en`=1 and `mod_en`=1, `wake` pulses for one cycle on each falling edge of the synchronised line. With `wake_en`=0 it stays 0.
- R13: `ren_q` is loaded from `ren_val` on `ren_wr`. While it is 0, frames are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_en | input | 1 | Module enable; 0 resets the receive path |
| ren_wr | input | 1 | Write strobe for the receiver enable |
| ren_val | input | 1 | Value written to the receiver enable |
| par_en | input | 1 | Even parity bit present and checked |
| len9 | input | 1 | 0: 8 data bits, 1: 9 data bits |
| addr_det | input | 1 | Drop 9-bit frames whose ninth bit is 0 |
| wake_en | input | 1 | Enable the falling-edge wake strobe |
| rie | input | 1 | Receive interrupt enable |
| tick16 | input | 1 | One-cycle strobe at 16x the bit rate |
| rxd | input | 1 | Asynchronous serial input, idle high |
| rd_strobe | input | 1 | Character read; clears rxif and oerr |
| ren_q | output | 1 | Receiver enable state |
| rdata | output | 8 | Held character, low eight bits |
| rbit8 | output | 1 | Held character, ninth bit |
| rxif | output | 1 | Character held |
| oerr | output | 1 | Overrun |
| ferr | output | 1 | Stop bit read 0 |
| perr | output | 1 | Parity mismatch |
| nf | output | 1 | Sample disagreement seen |
| ridle | output | 1 | No frame in progress |
| wake | output | 1 | Wake strobe |
| irq | output | 1 | Receive interrupt request |

## Verification
A line change reaches the sequencer two clocks later, through the synchroniser. The stop bit is resolved on the ninth tick of its period, and the holding register and flags update one clock after that, so a character is always visible before its stop period ends. The bench therefore samples every frame result six clocks after the whole stop period has been driven, and `rd_strobe` effects one clock after the strobe. `ridle` is probed deep inside a frame, the disable effects are probed three clocks after `mod_en` falls, and wake pulses are counted on every falling clock edge while a frame with a known number of falling transitions is sent.

// File: rtl/uart9_rx_pkg.sv
package uart9_rx_pkg;
    localparam int unsigned RX_DW = 9;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PARITY,
        S_STOP
    } rx_state_e;

    typedef struct packed {
        logic [RX_DW-1:0] data;
        logic             par_err;
        logic             frm_err;
        logic             noise;
    } rx_frame_t;
endpackage

// File: rtl/uart9_rx_sync.sv
module uart9_rx_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rxd,
    input  logic mod_en,
    input  logic wake_en,
    output logic rx_s,
    output logic wake
);
    logic [STAGES-1:0] chain;
    logic              rx_prev;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b1;
                    else        chain[0] <= rxd;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= 1'b1;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign rx_s = chain[STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rx_prev <= 1'b1;
        else        rx_prev <= rx_s;
    end

    assign wake = mod_en && wake_en && rx_prev && !rx_s;

    // R12
    wake_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake |=> !rx_prev);
endmodule

// File: rtl/uart9_rx_fsm.sv
module uart9_rx_fsm
    import uart9_rx_pkg::*;
#(
    parameter int unsigned OSR = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      active,
    input  logic      tick,
    input  logic      rx_s,
    input  logic      len9,
    input  logic      par_en,
    output logic      busy,
    output logic      done,
    output rx_frame_t frame
);
    localparam int unsigned SW = $clog2(OSR);
    localparam logic [SW-1:0] MID  = SW'(OSR / 2);
    localparam logic [SW-1:0] SA   = SW'(OSR / 2 - 1);
    localparam logic [SW-1:0] SC   = SW'(OSR / 2 + 1);
    localparam logic [SW-1:0] LAST = SW'(OSR - 1);
    localparam int unsigned BW = $clog2(RX_DW + 1);

    rx_state_e        st, nxt;
    logic [SW-1:0]    sub;
    logic [BW-1:0]    bit_idx;
    logic [BW-1:0]    last_data;
    logic [RX_DW-1:0] shreg;
    logic             s_a, s_b;
    logic             noise_acc, par_acc;
    logic             maj, dis, at_mid, at_end;

    always_comb begin
        maj       = (s_a & s_b) | (s_a & rx_s) | (s_b & rx_s);
        dis       = !((s_a == s_b) && (s_b == rx_s));
        at_mid    = tick && (sub == SC);
        at_end    = tick && (sub == LAST);
        last_data = len9 ? BW'(RX_DW - 1) : BW'(RX_DW - 2);
        nxt       = st;
        unique case (st)
            S_IDLE:   if (tick && !rx_s) nxt = S_START;
            S_START:  if (at_mid && maj) nxt = S_IDLE;
                      else if (at_end)   nxt = S_DATA;
            S_DATA:   if (at_end && bit_idx == last_data)
                          nxt = par_en ? S_PARITY : S_STOP;
            S_PARITY: if (at_end) nxt = S_STOP;
            S_STOP:   if (at_mid) nxt = S_IDLE;
            default:  nxt = S_IDLE;
        endcase
        if (!active) nxt = S_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= nxt;
    end

    // sampling datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sub       <= '0;
            bit_idx   <= '0;
            shreg     <= '0;
            s_a       <= 1'b1;
            s_b       <= 1'b1;
            noise_acc <= 1'b0;
            par_acc   <= 1'b0;
        end else if (!active) begin
            sub       <= '0;
            bit_idx   <= '0;
            noise_acc <= 1'b0;
            par_acc   <= 1'b0;
        end else if (tick) begin
            if (st == S_IDLE) begin
                sub       <= SW'(1);
                bit_idx   <= '0;
                noise_acc <= 1'b0;
                par_acc   <= 1'b0;
            end else begin
                sub <= sub + SW'(1);
                if (sub == SA)  s_a <= rx_s;
                if (sub == MID) s_b <= rx_s;
                if (sub == SC) begin
                    noise_acc <= noise_acc | dis;
                    if (st == S_DATA) begin
                        shreg   <= {maj, shreg[RX_DW-1:1]};
                        par_acc <= par_acc ^ maj;
                    end
                    if (st == S_PARITY) par_acc <= par_acc ^ maj;
                end
                if (sub == LAST && st == S_DATA) bit_idx <= bit_idx + BW'(1);
            end
        end
    end

    // outputs
    always_comb begin
        busy          = (st != S_IDLE);
        done          = (st == S_STOP) && at_mid;
        frame.data    = len9 ? shreg : {1'b0, shreg[RX_DW-1:1]};
        frame.par_err = par_en && par_acc;
        frame.frm_err = !maj;
        frame.noise   = noise_acc | dis;
    end

    // R9
    idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (st == S_IDLE));

    // R9
    start_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st) == S_IDLE && st == S_START) |-> $past(!rx_s && tick));
endmodule

// File: rtl/uart9_rx_status.sv
module uart9_rx_status
    import uart9_rx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      mod_en,
    input  logic      done,
    input  rx_frame_t frame,
    input  logic      len9,
    input  logic      addr_det,
    input  logic      rd,
    output logic [7:0] rdata,
    output logic      rbit8,
    output logic      rxif,
    output logic      oerr,
    output logic      ferr,
    output logic      perr,
    output logic      nf
);
    logic accept;

    assign accept = !(len9 && addr_det && !frame.data[RX_DW-1]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n || !mod_en) begin
            rdata <= '0;
            rbit8 <= 1'b0;
            rxif  <= 1'b0;
            oerr  <= 1'b0;
            ferr  <= 1'b0;
            perr  <= 1'b0;
            nf    <= 1'b0;
        end else begin
            if (rd) begin
                rxif <= 1'b0;
                oerr <= 1'b0;
            end
            if (done && accept) begin
                if (rxif && !rd) begin
                    oerr <= 1'b1;
                end else begin
                    rdata <= frame.data[7:0];
                    rbit8 <= frame.data[RX_DW-1];
                    ferr  <= frame.frm_err;
                    perr  <= frame.par_err;
                    nf    <= frame.noise;
                    rxif  <= 1'b1;
                end
            end
        end
    end

    // R10
    disable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mod_en |=> (!rxif && !oerr && !ferr && !perr && !nf && rdata == 8'h00));

    // R6
    oerr_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oerr) |-> $past(rxif && done));

    // R1
    rxif_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rxif) |-> $past(done));

    // R7
    addr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && len9 && addr_det && !frame.data[RX_DW-1] && !rxif) |=> !rxif);
endmodule

// File: rtl/uart9_rx.sv
module uart9_rx
    import uart9_rx_pkg::*;
#(
    parameter int unsigned OSR         = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mod_en,
    input  logic       ren_wr,
    input  logic       ren_val,
    input  logic       par_en,
    input  logic       len9,
    input  logic       addr_det,
    input  logic       wake_en,
    input  logic       rie,
    input  logic       tick16,
    input  logic       rxd,
    input  logic       rd_strobe,
    output logic       ren_q,
    output logic [7:0] rdata,
    output logic       rbit8,
    output logic       rxif,
    output logic       oerr,
    output logic       ferr,
    output logic       perr,
    output logic       nf,
    output logic       ridle,
    output logic       wake,
    output logic       irq
);
    logic      rx_s, busy, done;
    rx_frame_t frame;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ren_q <= 1'b0;
        else if (!mod_en) ren_q <= 1'b0;
        else if (ren_wr)  ren_q <= ren_val;
    end

    uart9_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .rxd     (rxd),
        .mod_en  (mod_en),
        .wake_en (wake_en),
        .rx_s    (rx_s),
        .wake    (wake)
    );

    uart9_rx_fsm #(.OSR(OSR)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (mod_en && ren_q),
        .tick   (tick16),
        .rx_s   (rx_s),
        .len9   (len9),
        .par_en (par_en),
        .busy   (busy),
        .done   (done),
        .frame  (frame)
    );

    uart9_rx_status u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .mod_en   (mod_en),
        .done     (done),
        .frame    (frame),
        .len9     (len9),
        .addr_det (addr_det),
        .rd       (rd_strobe),
        .rdata    (rdata),
        .rbit8    (rbit8),
        .rxif     (rxif),
        .oerr     (oerr),
        .ferr     (ferr),
        .perr     (perr),
        .nf       (nf)
    );

    assign ridle = !busy;
    assign irq   = rxif && rie;

    // R13
    rcv_off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ren_q |=> ridle);
endmodule

// File: tb/sim_uart9_rx.sv
module sim_uart9_rx;
    logic       clk = 1'b0;
    logic       rst_n, mod_en, ren_wr, ren_val, par_en, len9, addr_det;
    logic       wake_en, rie, rxd, rd_strobe;
    logic       tick16 = 1'b0;
    logic       ren_q, rbit8, rxif, oerr, ferr, perr, nf, ridle, wake, irq;
    logic [7:0] rdata;
    int         checks = 0;
    int         failures = 0;
    int         wake_cnt = 0;

    always #4 clk = ~clk;
    always @(negedge clk) tick16 <= ~tick16;
    always @(negedge clk) if (wake === 1'b1) wake_cnt <= wake_cnt + 1;

    uart9_rx u0 (
        .clk(clk), .rst_n(rst_n), .mod_en(mod_en), .ren_wr(ren_wr), .ren_val(ren_val),
        .par_en(par_en), .len9(len9), .addr_det(addr_det), .wake_en(wake_en), .rie(rie),
        .tick16(tick16), .rxd(rxd), .rd_strobe(rd_strobe), .ren_q(ren_q), .rdata(rdata),
        .rbit8(rbit8), .rxif(rxif), .oerr(oerr), .ferr(ferr), .perr(perr), .nf(nf),
        .ridle(ridle), .wake(wake), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one bit period is 16 ticks = 32 clocks; a glitch inverts clocks 16..17 (sample 8)
    task automatic drive_bit(input logic v, input bit glitch);
        rxd = v;
        if (glitch) begin
            repeat (16) @(negedge clk);
            rxd = ~v;
            repeat (2) @(negedge clk);
            rxd = v;
            repeat (14) @(negedge clk);
        end else begin
            repeat (32) @(negedge clk);
        end
    endtask

    task automatic send_frame(input logic [8:0] d, input bit l9, input bit pe,
                              input bit bad_par, input bit bad_stop, input int gbit);
        int   nd;
        logic p;
        nd = l9 ? 9 : 8;
        p  = 1'b0;
        drive_bit(1'b0, 1'b0);
        for (int i = 0; i < nd; i++) begin
            drive_bit(d[i], gbit == i);
            p = p ^ d[i];
        end
        if (pe) drive_bit(p ^ bad_par, 1'b0);
        if (bad_stop) begin
            rxd = 1'b0;
            repeat (24) @(negedge clk);
            rxd = 1'b1;
            repeat (8) @(negedge clk);
        end else begin
            drive_bit(1'b1, 1'b0);
        end
        repeat (6) @(negedge clk);
    endtask

    task automatic do_read();
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        @(negedge clk);
    endtask

    task automatic write_ren(input logic v);
        ren_wr  = 1'b1;
        ren_val = v;
        @(negedge clk);
        ren_wr  = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0; mod_en = 1'b1; ren_wr = 1'b0; ren_val = 1'b0; par_en = 1'b0;
        len9 = 1'b0; addr_det = 1'b0; wake_en = 1'b0; rie = 1'b0; rxd = 1'b1; rd_strobe = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 reset ridle", ridle, 1);
        check("R1 reset rxif", rxif, 0);
        check("R8 reset irq", irq, 0);
        check("R13 reset ren_q", ren_q, 0);
        check("R6 reset oerr", oerr, 0);

        // R13: receiver off ignores a frame
        send_frame(9'h05A, 1'b0, 1'b0, 1'b0, 1'b0, -1);
        check("R13 ignored while off", rxif, 0);
        write_ren(1'b1);
        check("R13 ren_q written", ren_q, 1);

        // sweep over length and parity settings
        for (int cfg = 0; cfg < 4; cfg++) begin
            len9   = cfg[0];
            par_en = cfg[1];
            for (int v = 0; v < 12; v++) begin
                logic [8:0] d;
                d   = 9'((v * 53 + cfg * 29 + 3) & 9'h1FF);
                rie = v[0];
                send_frame(d, len9, par_en, 1'b0, 1'b0, -1);
                check("R1 rdata", rdata, d[7:0]);
                check("R2 rbit8", rbit8, len9 ? d[8] : 1'b0);
                check("R1 rxif", rxif, 1);
                check("R3 perr clean", perr, 0);
                check("R5 ferr clean", ferr, 0);
                check("R4 nf clean", nf, 0);
                check("R8 irq", irq, v[0]);
                do_read();
                check("R6 read clears rxif", rxif, 0);
            end
        end
        len9 = 1'b0; par_en = 1'b1; rie = 1'b0;

        // R3 parity mismatch
        send_frame(9'h03C, 1'b0, 1'b1, 1'b1, 1'b0, -1);
        check("R3 perr set", perr, 1);
        check("R3 data kept", rdata, 8'h3C);
        do_read();
        par_en = 1'b0;

        // R4 disagreement on the middle sample of data bit 3
        send_frame(9'h0A5, 1'b0, 1'b0, 1'b0, 1'b0, 3);
        check("R4 nf set", nf, 1);
        check("R4 majority data", rdata, 8'hA5);
        do_read();

        // R5 stop bit low
        send_frame(9'h081, 1'b0, 1'b0, 1'b0, 1'b1, -1);
        check("R5 ferr set", ferr, 1);
        check("R5 stored", rdata, 8'h81);
        do_read();
        repeat (40) @(negedge clk);
        check("R9 false start rejected", ridle, 1);
        check("R5 no extra char", rxif, 0);

        // R6 overrun
        send_frame(9'h011, 1'b0, 1'b0, 1'b0, 1'b0, -1);
        send_frame(9'h022, 1'b0, 1'b0, 1'b0, 1'b0, -1);
        check("R6 oerr set", oerr, 1);
        check("R6 first kept", rdata, 8'h11);
        do_read();
        check("R6 read clears oerr", oerr, 0);
        check("R6 read clears rxif", rxif, 0);
        send_frame(9'h033, 1'b0, 1'b0, 1'b0, 1'b0, -1);
        check("R6 next accepted", rdata, 8'h33);
        do_read();

        // R7 address filter
        len9 = 1'b1; addr_det = 1'b1;
        send_frame(9'h042, 1'b1, 1'b0, 1'b0, 1'b0, -1);
        check("R7 data frame dropped", rxif, 0);
        check("R7 rdata untouched", rdata, 8'h33);
        send_frame(9'h142, 1'b1, 1'b0, 1'b0, 1'b0, -1);
        check("R7 address accepted", rxif, 1);
        check("R7 rbit8", rbit8, 1);
        check("R7 address data", rdata, 8'h42);
        do_read();
        addr_det = 1'b0; len9 = 1'b0;

        // R9 busy during a frame
        fork
            send_frame(9'h00F, 1'b0, 1'b0, 1'b0, 1'b0, -1);
            begin
                repeat (100) @(negedge clk);
                check("R9 ridle low in frame", ridle, 0);
            end
        join
        check("R9 ridle after frame", ridle, 1);
        do_read();

        // R12 wake: 0x55 gives start fall plus four data falls = 5
        begin
            int c0;
            wake_en = 1'b1;
            c0 = wake_cnt;
            send_frame(9'h055, 1'b0, 1'b0, 1'b0, 1'b0, -1);
            check("R12 wake pulses", wake_cnt - c0, 5);
            do_read();
            wake_en = 1'b0;
            c0 = wake_cnt;
            send_frame(9'h055, 1'b0, 1'b0, 1'b0, 1'b0, -1);
            check("R12 wake disabled", wake_cnt - c0, 0);
            do_read();
        end

        // R10 / R11 module disable
        len9 = 1'b1; par_en = 1'b1; rie = 1'b1;
        send_frame(9'h077, 1'b1, 1'b1, 1'b0, 1'b0, -1);
        send_frame(9'h078, 1'b1, 1'b1, 1'b0, 1'b0, -1);
        check("R10 setup oerr", oerr, 1);
        fork
            send_frame(9'h099, 1'b1, 1'b1, 1'b0, 1'b0, -1);
            begin
                repeat (120) @(negedge clk);
                mod_en = 1'b0;
                repeat (3) @(negedge clk);
                check("R10 rxif cleared", rxif, 0);
                check("R10 oerr cleared", oerr, 0);
                check("R10 rdata cleared", rdata, 0);
                check("R10 ren_q cleared", ren_q, 0);
                check("R10 ridle set", ridle, 1);
                check("R10 irq low", irq, 0);
            end
        join
        repeat (20) @(negedge clk);
        mod_en = 1'b1;
        @(negedge clk);
        check("R10 abandoned frame absent", rxif, 0);
        check("R11 ren_q stays off", ren_q, 0);
        send_frame(9'h1C3, 1'b1, 1'b1, 1'b0, 1'b0, -1);
        check("R11 off until written", rxif, 0);
        write_ren(1'b1);
        send_frame(9'h1C3, 1'b1, 1'b1, 1'b0, 1'b0, -1);
        check("R11 config kept data", rdata, 8'hC3);
        check("R11 config kept ninth", rbit8, 1);
        check("R11 config kept parity", perr, 0);
        check("R8 irq enabled", irq, 1);
        do_read();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(negedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule